// File: doc/BRIEF.md
# Command Slot Scanner and Command FIS Decoder

This block serves one storage port of a host controller. Software marks pending commands by setting bits in a 32-slot issue bitmap. Once the port is enabled and a programmable settling delay has passed, the block walks the pending slots from the lowest index upward. For each slot it reads the command header and the first four words of the command frame from system memory, one word at a time, through a single-outstanding read port. It then decodes the frame into a task descriptor for an external data mover.

When the data mover reports the task finished, the block sets the completion status bit and retires the slot. Frames of the wrong type, with an unsupported opcode or a length that is too short are rejected. A rejected frame raises the error status bit and retires the slot, so the block never stalls on it. A well-formed register frame that is not a command is retired quietly. Scanning ends when the bitmap is empty, and it starts again only on the next trigger. One instance is placed per port.

Top module: `cmdSlotScanner`

## Requirements
- R1: With `portStart` low, writes to the issue bitmap or the command register start no processing. No memory request is made and the written issue bits stay set.
- R2: An issue or command write made while `portStart` is high starts processing. The first memory request comes no sooner than `DELAY_CYCLES` cycles after that write and no later than `DELAY_CYCLES`+4 cycles after it. A further write during the delay restarts the delay.
- R3: A slot's six reads are made in this order. The first two are header word 0 at `listBase` + slot×32 and header word 2 at `listBase` + slot×32 + 8. The other four are frame words at T, T+4, T+8 and T+12, where T is header word 2. Only one request is outstanding at a time, and every address is word aligned.
- R4: Each write to the issue bitmap ORs its data into the bitmap. Pending slots are served one at a time, always taking the lowest set index first, so service runs in ascending slot order.
- R5: Frame bytes are taken little-endian from the words. The task opcode is frame byte 2. The LBA is built from bytes 4, 5, 6, 8, 9 and 10, which become LBA bits 7:0, 15:8, 23:16, 31:24, 39:32 and 47:40. The sector count is byte 12 | byte 13<<8, and a count of 0 is reported as 256.
- R6: `taskSgBase` equals header word 2 + 0x80. `taskEntries` equals header word 0 bits 31:16. `taskSlot` is the slot being served.
- R7: The task outputs hold steady while `taskValid` is high and `taskDone` is low. On `taskDone`, status bit 2 is set, the slot's issue bit clears and `taskValid` drops.
- R8: The frame is rejected if any of these holds: byte 0 is not 0x27, the opcode is not one of 0xEC, 0xEF, 0xC8 or 0xCA, or header word 0 bits 4:0 (frame length in words) is below 4. A rejected frame sets status bit 30, clears the slot's issue bit and issues no task.
- R9: A frame with byte 0 equal to 0x27 and byte 1 bit 7 clear is not a command. Its slot is cleared with no task and no status change.
- R10: Status bits are cleared by writing 1 to them through `irqClrWr`/`irqClrData`. A clear affects only the bits written. Status bits other than 2 and 30 read as 0.
- R11: Once the bitmap is empty the block goes idle and makes no memory request until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portStart | input | 1 | Port start-enable level |
| issueWr | input | 1 | Issue bitmap write strobe |
| issueData | input | SLOTS | Bits ORed into the issue bitmap |
| cmdWr | input | 1 | Port command register write strobe |
| listBase | input | 32 | Command list base address |
| memReqValid | output | 1 | Read request pulse |
| memReqAddr | output | 32 | Read request byte address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response word |
| taskValid | output | 1 | Task descriptor valid |
| taskSlot | output | SLOT_W | Slot of the task |
| taskOp | output | 8 | Command opcode |
| taskLba | output | 48 | Starting LBA |
| taskCount | output | 16 | Sector count (0 promoted to 256) |
| taskSgBase | output | 32 | Address of first scatter entry |
| taskEntries | output | 16 | Number of scatter entries |
| taskDone | input | 1 | Data mover completion pulse |
| irqClrWr | input | 1 | Status clear strobe |
| irqClrData | input | 32 | Write-1-to-clear mask |
| irqStat | output | 32 | Port status bits (2 done, 30 error) |
| issueBits | output | SLOTS | Current issue bitmap |

## Verification
The assertions rely on two assumptions about the memory side. First, `memRspValid` arrives only after a request and never while no request is outstanding. Second, `taskDone` is pulsed only while a task is presented. The bench's memory model answers every request exactly one cycle later, and its data-mover model raises `taskDone` for one cycle, a few cycles after it records the task, so neither assumption is violated. Several distinct slot masks and data variants are used. Each expected descriptor is computed arithmetically from the slot number and the variant.

// File: rtl/scanPkg.sv
package scanPkg;
  localparam int WORD_W   = 32;
  localparam int DONE_BIT = 2;
  localparam int ERR_BIT  = 30;

  localparam logic [7:0] FRAME_TYPE_CMD = 8'h27;
  localparam logic [7:0] OP_IDENTIFY    = 8'hEC;
  localparam logic [7:0] OP_SETFEAT     = 8'hEF;
  localparam logic [7:0] OP_DMA_RD      = 8'hC8;
  localparam logic [7:0] OP_DMA_WR      = 8'hCA;

  typedef struct packed {
    logic loadSlot;
    logic memReq;
    logic capture;
    logic loadTask;
    logic setDone;
    logic setErr;
    logic clearSlot;
  } scanStrobes_t;

  typedef enum logic [1:0] {
    FRAME_OK     = 2'd0,
    FRAME_NONCMD = 2'd1,
    FRAME_BAD    = 2'd2
  } frameKind_t;
endpackage

// File: rtl/scanCtl.sv
module scanCtl
  import scanPkg::*;
#(
  parameter int DELAY_CYCLES = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         portStart,
  input  logic         issueWr,
  input  logic         cmdWr,
  input  logic         anyIssue,
  input  logic         hdrShort,
  input  frameKind_t   frameKind,
  input  logic         rspValid,
  input  logic         taskDone,
  output scanStrobes_t stb,
  output logic [2:0]   wordIdx
);
  localparam int DLY_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY_CYCLES - 1);
  localparam logic [2:0] LAST_WORD = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_SCAN, S_REQ, S_RSP, S_DECIDE, S_TASK
  } state_t;

  state_t stateQ, stateD;
  logic [DLY_W-1:0] dlyQ, dlyD;
  logic [2:0] idxD;
  logic trig;

  assign trig = (issueWr | cmdWr) & portStart;

  always_comb begin
    stateD = stateQ;
    dlyD   = dlyQ;
    idxD   = wordIdx;
    stb    = '0;
    unique case (stateQ)
      S_IDLE: if (trig) begin stateD = S_WAIT; dlyD = DLY_LOAD; end
      S_WAIT: begin
        if (trig) dlyD = DLY_LOAD;
        else if (dlyQ == '0) stateD = S_SCAN;
        else dlyD = dlyQ - 1'b1;
      end
      S_SCAN: begin
        if (anyIssue) begin
          stb.loadSlot = 1'b1;
          idxD = 3'd0;
          stateD = S_REQ;
        end else if (trig) begin
          stateD = S_WAIT;
          dlyD = DLY_LOAD;
        end else begin
          stateD = S_IDLE;
        end
      end
      S_REQ: begin
        stb.memReq = 1'b1;
        stateD = S_RSP;
      end
      S_RSP: if (rspValid) begin
        stb.capture = 1'b1;
        if (wordIdx == 3'd1 && hdrShort) begin
          stb.setErr = 1'b1;
          stb.clearSlot = 1'b1;
          stateD = S_SCAN;
        end else if (wordIdx == LAST_WORD) begin
          stateD = S_DECIDE;
        end else begin
          idxD = wordIdx + 3'd1;
          stateD = S_REQ;
        end
      end
      S_DECIDE: begin
        unique case (frameKind)
          FRAME_OK: begin stb.loadTask = 1'b1; stateD = S_TASK; end
          FRAME_NONCMD: begin stb.clearSlot = 1'b1; stateD = S_SCAN; end
          default: begin
            stb.setErr = 1'b1;
            stb.clearSlot = 1'b1;
            stateD = S_SCAN;
          end
        endcase
      end
      S_TASK: if (taskDone) begin
        stb.setDone = 1'b1;
        stb.clearSlot = 1'b1;
        stateD = S_SCAN;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      dlyQ    <= '0;
      wordIdx <= '0;
    end else begin
      stateQ  <= stateD;
      dlyQ    <= dlyD;
      wordIdx <= idxD;
    end
  end

  // R3: a request is never followed directly by another one
  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.memReq |=> !stb.memReq);

  // R2: no request while the start delay is still running
  assert_no_early_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WAIT) |=> !stb.memReq);
endmodule

// File: rtl/scanData.sv
module scanData
  import scanPkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobes_t       stb,
  input  logic [2:0]         wordIdx,
  input  logic               issueWr,
  input  logic [SLOTS-1:0]   issueData,
  input  logic [WORD_W-1:0]  listBase,
  input  logic [WORD_W-1:0]  rspData,
  input  logic               taskDone,
  input  logic               irqClrWr,
  input  logic [WORD_W-1:0]  irqClrData,
  output logic               anyIssue,
  output logic               hdrShort,
  output frameKind_t         frameKind,
  output logic [WORD_W-1:0]  memReqAddr,
  output logic [SLOTS-1:0]   issueBits,
  output logic               taskValid,
  output logic [SLOT_W-1:0]  taskSlot,
  output logic [7:0]         taskOp,
  output logic [47:0]        taskLba,
  output logic [15:0]        taskCount,
  output logic [WORD_W-1:0]  taskSgBase,
  output logic [15:0]        taskEntries,
  output logic [WORD_W-1:0]  irqStat
);
  localparam int HDR_SHIFT = 5;
  localparam logic [WORD_W-1:0] SG_OFFSET = WORD_W'(32'h80);
  localparam logic [4:0] MIN_FRAME_WORDS = 5'd4;
  localparam logic [15:0] ZERO_COUNT_SECTORS = 16'd256;

  logic [SLOTS-1:0]  issueQ;
  logic [SLOT_W-1:0] slotQ, pick;
  logic [WORD_W-1:0] hdrW0, hdrW2;
  logic [WORD_W-1:0] frameW [4];
  logic doneQ, errQ;

  logic [7:0]  fType, fFlags, fOp;
  logic [15:0] rawCount;
  logic        opOk;

  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (issueQ[i]) pick = SLOT_W'(i);
  end

  assign anyIssue = |issueQ;
  assign hdrShort = hdrW0[4:0] < MIN_FRAME_WORDS;

  assign fType    = frameW[0][7:0];
  assign fFlags   = frameW[0][15:8];
  assign fOp      = frameW[0][23:16];
  assign rawCount = frameW[3][15:0];

  always_comb begin
    unique case (fOp)
      OP_IDENTIFY, OP_SETFEAT, OP_DMA_RD, OP_DMA_WR: opOk = 1'b1;
      default: opOk = 1'b0;
    endcase
    if (fType != FRAME_TYPE_CMD) frameKind = FRAME_BAD;
    else if (!fFlags[7])         frameKind = FRAME_NONCMD;
    else if (!opOk)              frameKind = FRAME_BAD;
    else                         frameKind = FRAME_OK;
  end

  always_comb begin
    if (wordIdx < 3'd2)
      memReqAddr = listBase + (WORD_W'(slotQ) << HDR_SHIFT)
                 + ((wordIdx == 3'd1) ? WORD_W'(8) : WORD_W'(0));
    else
      memReqAddr = hdrW2 + WORD_W'({wordIdx - 3'd2, 2'b00});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueQ      <= '0;
      slotQ       <= '0;
      hdrW0       <= '0;
      hdrW2       <= '0;
      for (int k = 0; k < 4; k++) frameW[k] <= '0;
      taskValid   <= 1'b0;
      taskSlot    <= '0;
      taskOp      <= '0;
      taskLba     <= '0;
      taskCount   <= '0;
      taskSgBase  <= '0;
      taskEntries <= '0;
      doneQ       <= 1'b0;
      errQ        <= 1'b0;
    end else begin
      issueQ <= (issueQ & ~(stb.clearSlot ? (SLOTS'(1) << slotQ) : '0))
              | (issueWr ? issueData : '0);
      if (stb.loadSlot) slotQ <= pick;
      if (stb.capture) begin
        unique case (wordIdx)
          3'd0: hdrW0 <= rspData;
          3'd1: hdrW2 <= rspData;
          3'd2: frameW[0] <= rspData;
          3'd3: frameW[1] <= rspData;
          3'd4: frameW[2] <= rspData;
          default: frameW[3] <= rspData;
        endcase
      end
      if (stb.loadTask) begin
        taskValid   <= 1'b1;
        taskSlot    <= slotQ;
        taskOp      <= fOp;
        taskLba     <= {frameW[2][23:0], frameW[1][23:0]};
        taskCount   <= (rawCount == '0) ? ZERO_COUNT_SECTORS : rawCount;
        taskSgBase  <= hdrW2 + SG_OFFSET;
        taskEntries <= hdrW0[31:16];
      end else if (stb.setDone) begin
        taskValid <= 1'b0;
      end
      doneQ <= (doneQ & ~(irqClrWr & irqClrData[DONE_BIT])) | stb.setDone;
      errQ  <= (errQ & ~(irqClrWr & irqClrData[ERR_BIT])) | stb.setErr;
    end
  end

  assign issueBits = issueQ;

  always_comb begin
    irqStat = '0;
    irqStat[DONE_BIT] = doneQ;
    irqStat[ERR_BIT]  = errQ;
  end

  // R7: completion only retires a task that is being presented
  assert_done_has_task_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.setDone |-> taskValid);

  // R7: descriptor held until the data mover finishes
  assert_task_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (taskValid && !taskDone) |=> (taskValid && $stable(taskLba) && $stable(taskSlot)));

  // R5: a presented count is never zero
  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    taskValid |-> (taskCount != '0));

  // R4: a task is only built for a slot that is still pending
  assert_task_slot_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTask |-> issueQ[slotQ]);

  // R3: requests are word aligned
  assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.memReq |-> (memReqAddr[1:0] == 2'b00));
endmodule

// File: rtl/cmdSlotScanner.sv
module cmdSlotScanner
  import scanPkg::*;
#(
  parameter int SLOTS        = 32,
  parameter int DELAY_CYCLES = 1000,
  parameter int SLOT_W       = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               portStart,
  input  logic               issueWr,
  input  logic [SLOTS-1:0]   issueData,
  input  logic               cmdWr,
  input  logic [31:0]        listBase,
  output logic               memReqValid,
  output logic [31:0]        memReqAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  output logic               taskValid,
  output logic [SLOT_W-1:0]  taskSlot,
  output logic [7:0]         taskOp,
  output logic [47:0]        taskLba,
  output logic [15:0]        taskCount,
  output logic [31:0]        taskSgBase,
  output logic [15:0]        taskEntries,
  input  logic               taskDone,
  input  logic               irqClrWr,
  input  logic [31:0]        irqClrData,
  output logic [31:0]        irqStat,
  output logic [SLOTS-1:0]   issueBits
);
  scanStrobes_t stb;
  logic [2:0]   wordIdx;
  logic         anyIssue, hdrShort;
  frameKind_t   frameKind;

  scanCtl #(.DELAY_CYCLES(DELAY_CYCLES)) ctl (
    .clk(clk), .rstN(rstN), .portStart(portStart), .issueWr(issueWr),
    .cmdWr(cmdWr), .anyIssue(anyIssue), .hdrShort(hdrShort),
    .frameKind(frameKind), .rspValid(memRspValid), .taskDone(taskDone),
    .stb(stb), .wordIdx(wordIdx)
  );

  scanData #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wordIdx(wordIdx),
    .issueWr(issueWr), .issueData(issueData), .listBase(listBase),
    .rspData(memRspData), .taskDone(taskDone), .irqClrWr(irqClrWr),
    .irqClrData(irqClrData), .anyIssue(anyIssue), .hdrShort(hdrShort),
    .frameKind(frameKind), .memReqAddr(memReqAddr), .issueBits(issueBits),
    .taskValid(taskValid), .taskSlot(taskSlot), .taskOp(taskOp),
    .taskLba(taskLba), .taskCount(taskCount), .taskSgBase(taskSgBase),
    .taskEntries(taskEntries), .irqStat(irqStat)
  );

  assign memReqValid = stb.memReq;
endmodule

// File: tb/cmdSlotScanner_test.sv
module cmdSlotScanner_test;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY = 40;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] TBL  = 32'h500;

  logic clk = 1'b0, rstN = 1'b0;
  logic portStart = 1'b0, issueWr = 1'b0, cmdWr = 1'b0, irqClrWr = 1'b0;
  logic [31:0] issueData = '0, irqClrData = '0;
  logic memReqValid, memRspValid = 1'b0;
  logic [31:0] memReqAddr, memRspData = '0;
  logic taskValid, taskDone = 1'b0;
  logic [4:0] taskSlot;
  logic [7:0] taskOp;
  logic [47:0] taskLba;
  logic [15:0] taskCount, taskEntries;
  logic [31:0] taskSgBase, irqStat, issueBits;

  cmdSlotScanner #(.SLOTS(32), .DELAY_CYCLES(DELAY)) uut (
    .clk(clk), .rstN(rstN), .portStart(portStart), .issueWr(issueWr),
    .issueData(issueData), .cmdWr(cmdWr), .listBase(BASE),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .taskValid(taskValid), .taskSlot(taskSlot), .taskOp(taskOp),
    .taskLba(taskLba), .taskCount(taskCount), .taskSgBase(taskSgBase),
    .taskEntries(taskEntries), .taskDone(taskDone), .irqClrWr(irqClrWr),
    .irqClrData(irqClrData), .irqStat(irqStat), .issueBits(issueBits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] mem [0:511];
  int cyc = 0, trigCyc = 0, reqCount = 0, nRec = 0, stableErr = 0;
  logic [31:0] reqAddr [0:2047];
  int reqCyc [0:2047];
  int recSlot [0:255];
  logic [7:0] recOp [0:255];
  logic [47:0] recLba [0:255];
  logic [15:0] recCnt [0:255];
  logic [15:0] recEnt [0:255];
  logic [31:0] recSg [0:255];
  int mvState = 0, mvCnt = 0;
  logic [47:0] mvLba;

  // memory model: one-cycle response, logs every request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (issueWr || cmdWr) trigCyc <= cyc;
    memRspValid <= memReqValid;
    if (memReqValid) begin
      memRspData <= mem[memReqAddr[10:2]];
      if (reqCount < 2048) begin
        reqAddr[reqCount] <= memReqAddr;
        reqCyc[reqCount] <= cyc;
      end
      reqCount <= reqCount + 1;
    end
  end

  // data mover model
  always @(posedge clk) begin
    case (mvState)
      0: if (taskValid) begin
        recSlot[nRec] <= int'(taskSlot);
        recOp[nRec] <= taskOp;
        recLba[nRec] <= taskLba;
        recCnt[nRec] <= taskCount;
        recEnt[nRec] <= taskEntries;
        recSg[nRec] <= taskSgBase;
        nRec <= nRec + 1;
        mvLba <= taskLba;
        mvCnt <= 3;
        mvState <= 1;
      end
      1: begin
        if (!taskValid || taskLba != mvLba) stableErr <= stableErr + 1;
        if (mvCnt == 0) begin taskDone <= 1'b1; mvState <= 2; end
        else mvCnt <= mvCnt - 1;
      end
      default: begin taskDone <= 1'b0; mvState <= 0; end
    endcase
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] opFor(input int s);
    case (s % 4)
      0: return 8'hEC;
      1: return 8'hEF;
      2: return 8'hC8;
      default: return 8'hCA;
    endcase
  endfunction

  function automatic logic [47:0] lbaFor(input int s, input int v);
    return {8'(s + 8'h40), 8'(s ^ 8'h5A), 8'(s * 3), 8'(s + 1), 8'(s * 7 + v), 8'(~s)}
           ^ {40'h0, 8'(v * 17)};
  endfunction

  function automatic logic [15:0] rawCntFor(input int s, input int v);
    return (s % 8 == 0) ? 16'h0 : 16'(s * 37 + v * 300 + 1);
  endfunction

  task automatic putSlot(input int s, input int v, input logic [7:0] typ,
                         input logic [7:0] flg, input logic [7:0] op,
                         input logic [4:0] len);
    logic [31:0] h, t;
    logic [47:0] l;
    logic [15:0] c;
    h = BASE + 32'(s * 32);
    t = TBL + 32'(s * 16);
    l = lbaFor(s, v);
    c = rawCntFor(s, v);
    mem[h[10:2]] = {16'(s + 1 + v), 11'h0, len};
    mem[h[10:2] + 1] = 32'hDEAD_0000;
    mem[h[10:2] + 2] = t;
    mem[t[10:2]] = {8'h00, op, flg, typ};
    mem[t[10:2] + 1] = {8'hE0, l[23:0]};
    mem[t[10:2] + 2] = {8'h00, l[47:24]};
    mem[t[10:2] + 3] = {16'h0, c};
  endtask

  task automatic putGood(input int s, input int v);
    putSlot(s, v, 8'h27, 8'h80, opFor(s), 5'd5);
  endtask

  task automatic issueWrite(input logic [31:0] d);
    @(negedge clk); issueWr = 1'b1; issueData = d;
    @(negedge clk); issueWr = 1'b0; issueData = '0;
  endtask

  task automatic clrWrite(input logic [31:0] d);
    @(negedge clk); irqClrWr = 1'b1; irqClrData = d;
    @(negedge clk); irqClrWr = 1'b0; irqClrData = '0;
  endtask

  task automatic waitQuiet();
    int n = 0;
    while ((issueBits != 0 || taskValid) && n < 20000) begin
      @(negedge clk); n++;
    end
    if (n >= 20000) chk("watchdog wait", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkRec(input int k, input int s, input int v, input string tag);
    logic [15:0] c;
    c = rawCntFor(s, v);
    chk({tag, " R4 slot order"}, recSlot[k], s);
    chk({tag, " R5 opcode"}, recOp[k], opFor(s));
    chk({tag, " R5 lba"}, recLba[k], lbaFor(s, v));
    chk({tag, " R5 count"}, recCnt[k], (c == 0) ? 16'd256 : c);
    chk({tag, " R6 sg base"}, recSg[k], TBL + 32'(s * 16) + 32'h80);
    chk({tag, " R6 entries"}, recEnt[k], 16'(s + 1 + v));
  endtask

  task automatic runMask(input logic [31:0] mask, input int v, input string tag);
    int n0, k;
    for (int s = 0; s < 32; s++) if (mask[s]) putGood(s, v);
    n0 = nRec;
    issueWrite(mask);
    waitQuiet();
    chk({tag, " R4 task count"}, nRec - n0, $countones(mask));
    k = n0;
    for (int s = 0; s < 32; s++) if (mask[s]) begin
      checkRec(k, s, v, tag);
      k++;
    end
    chk({tag, " R7 issue cleared"}, issueBits, 0);
    chk({tag, " R7 done bit"}, irqStat[2], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, n0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset issue", issueBits, 0);
    chk("reset irq", irqStat, 0);
    chk("reset task", taskValid, 0);
    chk("reset req", memReqValid, 0);

    // R1: start low
    putGood(0, 0);
    r0 = reqCount;
    issueWrite(32'h1);
    repeat (DELAY + 30) @(negedge clk);
    chk("R1 no request", reqCount - r0, 0);
    chk("R1 bit kept", issueBits, 1);

    // R2/R3: command write with start high
    portStart = 1'b1;
    @(negedge clk); cmdWr = 1'b1;
    @(negedge clk); cmdWr = 1'b0;
    n0 = nRec;
    waitQuiet();
    chk("R2 delay lower", (reqCyc[r0] - trigCyc) >= DELAY, 1);
    chk("R2 delay upper", (reqCyc[r0] - trigCyc) <= DELAY + 4, 1);
    chk("R3 req count", reqCount - r0, 6);
    chk("R3 hdr w0", reqAddr[r0], BASE);
    chk("R3 hdr w2", reqAddr[r0 + 1], BASE + 8);
    for (int w = 0; w < 4; w++) chk("R3 frame word", reqAddr[r0 + 2 + w], TBL + 32'(4 * w));
    chk("R7 one task", nRec - n0, 1);
    checkRec(n0, 0, 0, "first");
    chk("R7 issue cleared", issueBits, 0);
    chk("R7 done bit", irqStat, 32'h4);

    // R11: idle after empty bitmap
    r0 = reqCount;
    repeat (DELAY + 30) @(negedge clk);
    chk("R11 idle", reqCount - r0, 0);

    // sweeps
    runMask(32'hFFFF_FFFF, 1, "all");
    runMask(32'h8001_0240, 2, "sparse");
    runMask(32'h0000_00AA, 3, "odd");

    // R4: two writes OR together during delay
    putGood(1, 4); putGood(2, 4);
    n0 = nRec;
    issueWrite(32'h2);
    issueWrite(32'h4);
    chk("R4 or merge", issueBits, 32'h6);
    waitQuiet();
    chk("R4 both served", nRec - n0, 2);
    checkRec(n0, 1, 4, "merge");
    checkRec(n0 + 1, 2, 4, "merge");
    chk("R7 stable hold", stableErr, 0);

    // R10: clear done bit
    clrWrite(32'h4);
    chk("R10 w1c done", irqStat, 0);

    // R9: non-command frame
    putSlot(7, 0, 8'h27, 8'h00, 8'hC8, 5'd5);
    n0 = nRec;
    issueWrite(32'h80);
    waitQuiet();
    chk("R9 no task", nRec - n0, 0);
    chk("R9 no status", irqStat, 0);
    chk("R9 slot cleared", issueBits, 0);

    // R8: rejects plus one good slot
    putSlot(3, 0, 8'h34, 8'h80, 8'hC8, 5'd5);
    putSlot(4, 0, 8'h27, 8'h80, 8'h20, 5'd5);
    putSlot(6, 0, 8'h27, 8'h80, 8'hCA, 5'd2);
    putSlot(7, 0, 8'h27, 8'h00, 8'hC8, 5'd5);
    putGood(9, 5);
    n0 = nRec;
    issueWrite(32'h2D8);
    waitQuiet();
    chk("R8 only good task", nRec - n0, 1);
    chk("R8 good slot", recSlot[n0], 9);
    chk("R8 err and done", irqStat, 32'h4000_0004);
    chk("R8 all cleared", issueBits, 0);

    // R8: short length alone skips frame fetch
    clrWrite(32'h4000_0004);
    r0 = reqCount;
    issueWrite(32'h40);
    waitQuiet();
    chk("R8 short fetch", reqCount - r0, 2);
    chk("R8 short err", irqStat, 32'h4000_0000);

    // R10: selective clear
    putGood(5, 6);
    issueWrite(32'h20);
    waitQuiet();
    clrWrite(32'h4000_0000);
    chk("R10 selective", irqStat, 32'h4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule